// File: doc/BRIEF.md
# Shared-Port Dual-Channel Request Scheduler

This scheduler sits behind a single crossbar port that has to feed two memory channels: the striped channel (index 0) and the buddy channel (index 1). Each channel presents a pending-read flag and a pending-write flag taken from the heads of the read and write queues. Every cycle the scheduler grants some of these requests. The grants pop the queue heads in the same cycle, and one cycle later they appear as command strobes toward the channels.

When the buddy link is active, both channels share one read-return bus and one write-data bus. Two reads, or two writes, can therefore never issue in the same cycle. A read on one channel paired with a write on the other runs at full rate, so the scheduler looks for that pairing first. If no pairing exists, it settles same-type conflicts by priority. The striped channel normally wins these conflicts. A starvation counter hands priority to the buddy channel after it has been denied for `STARVE_LIM` consecutive cycles. When the buddy link is off, each channel has its own buses and is scheduled on its own.

For verification, one counter per channel records the cycles in which that channel had work but received no grant.

Top module: `shared_port_sched`

## Requirements
- R1: After reset, the command strobes and both idle counters are zero, and the striped channel holds priority. In a bit vector, bit 0 is the striped channel and bit 1 is the buddy channel.
- R2: A grant goes only to a channel whose matching request is high. A channel receives at most one grant (read or write) per cycle.
- R3: With `buddy_mode` high, no more than one read grant and no more than one write grant are given in any cycle.
- R4: With `buddy_mode` high, if a read is pending on one channel and a write on the other, both are granted together. If both such pairings exist, the pairing that gives the read to the priority channel is chosen.
- R5: With `buddy_mode` high and no cross pairing available, a same-type conflict is won by the priority channel. If a single channel has both a read and a write pending, its read is granted.
- R6: With `buddy_mode` high, after `STARVE_LIM` consecutive cycles in which the buddy channel requested and got no grant, the buddy channel takes priority. The count restarts whenever the buddy channel is granted, makes no request, or `buddy_mode` is low.
- R7: With `buddy_mode` low, each channel is granted its read if one is pending, otherwise its write, with no effect from the other channel.
- R8: `rd_cmd` and `wr_cmd` equal the read and write grants of the previous cycle.
- R9: A channel's idle counter increases by one, wrapping, at the clock edge that ends a cycle in which that channel requested and received no grant. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buddy_mode | input | 1 | High when both channels share the single read and write buses |
| rd_req | input | 2 | Read pending per channel (bit 0 striped, bit 1 buddy) |
| wr_req | input | 2 | Write pending per channel |
| rd_gnt | output | 2 | Read grant per channel, same cycle, pops the read queue head |
| wr_gnt | output | 2 | Write grant per channel, same cycle, pops the write queue head |
| rd_cmd | output | 2 | Registered read command strobe per channel |
| wr_cmd | output | 2 | Registered write command strobe per channel |
| idle_striped | output | CNT_W | Blocked-idle cycle count of the striped channel |
| idle_buddy | output | CNT_W | Blocked-idle cycle count of the buddy channel |

## Verification
Grants are combinational and are due in the same cycle that the requests are presented. Command strobes, idle counts and the priority change from starvation take effect one rising edge later. The bench drives requests on the falling edge and reads the grants 2 ns afterwards, before the next rising edge. It reads the strobes and counters 1 ns after that rising edge, and it then advances its own starvation and idle models, so every value is compared in the cycle it is due.

// File: rtl/shared_port_pkg.sv
package shared_port_pkg;
    localparam int NCH     = 2;
    localparam int STRIPED = 0;
    localparam int BUDDY   = 1;

    typedef logic [NCH-1:0] chmask_t;

    typedef struct packed {
        chmask_t rd;
        chmask_t wr;
    } grant_t;

    typedef struct packed {
        chmask_t rd_cmd;
        chmask_t wr_cmd;
    } cmd_t;
endpackage

// File: rtl/pair_pick.sv
module pair_pick
    import shared_port_pkg::*;
(
    input  chmask_t rd_req,
    input  chmask_t wr_req,
    input  logic    buddy_mode,
    input  logic    prio_buddy,
    output grant_t  gnt
);
    logic    pair_a;
    logic    pair_b;
    chmask_t prio_mask;

    always_comb begin
        gnt       = '0;
        pair_a    = rd_req[STRIPED] && wr_req[BUDDY];
        pair_b    = rd_req[BUDDY] && wr_req[STRIPED];
        prio_mask = prio_buddy ? chmask_t'(2'b10) : chmask_t'(2'b01);
        if (!buddy_mode) begin
            for (int c = 0; c < NCH; c++) begin
                if (rd_req[c])      gnt.rd[c] = 1'b1;
                else if (wr_req[c]) gnt.wr[c] = 1'b1;
            end
        end else if (pair_a && pair_b) begin
            gnt.rd[prio_buddy ? BUDDY : STRIPED]  = 1'b1;
            gnt.wr[prio_buddy ? STRIPED : BUDDY]  = 1'b1;
        end else if (pair_a) begin
            gnt.rd[STRIPED] = 1'b1;
            gnt.wr[BUDDY]   = 1'b1;
        end else if (pair_b) begin
            gnt.rd[BUDDY]   = 1'b1;
            gnt.wr[STRIPED] = 1'b1;
        end else if (rd_req != '0) begin
            gnt.rd = (rd_req == '1) ? prio_mask : rd_req;
        end else if (wr_req != '0) begin
            gnt.wr = (wr_req == '1) ? prio_mask : wr_req;
        end
    end
endmodule

// File: rtl/buddy_starve_ctr.sv
module buddy_starve_ctr #(
    parameter int STARVE_LIM = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic deny,
    output logic promote
);
    localparam int SW = $clog2(STARVE_LIM + 1);
    localparam logic [SW-1:0] LIM_V = SW'(STARVE_LIM);

    logic [SW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (deny) cnt_d = (cnt_q == LIM_V) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign promote = (cnt_q == LIM_V);

    // R6: once promoted, the buddy channel must win and never be denied
    assert_promoted_not_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
        promote |-> !deny);
endmodule

// File: rtl/blocked_idle_ctr.sv
module blocked_idle_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blocked,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (blocked) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/shared_port_sched.sv
module shared_port_sched
    import shared_port_pkg::*;
#(
    parameter int STARVE_LIM = 4,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buddy_mode,
    input  logic [1:0]       rd_req,
    input  logic [1:0]       wr_req,
    output logic [1:0]       rd_gnt,
    output logic [1:0]       wr_gnt,
    output logic [1:0]       rd_cmd,
    output logic [1:0]       wr_cmd,
    output logic [CNT_W-1:0] idle_striped,
    output logic [CNT_W-1:0] idle_buddy
);
    grant_t           gnt;
    logic             prio_buddy;
    chmask_t          blocked;
    cmd_t             cmd_d, cmd_q;
    logic [CNT_W-1:0] idle_cnt [NCH];

    pair_pick u_pick (
        .rd_req     (rd_req),
        .wr_req     (wr_req),
        .buddy_mode (buddy_mode),
        .prio_buddy (prio_buddy),
        .gnt        (gnt)
    );

    assign blocked = (rd_req | wr_req) & ~(gnt.rd | gnt.wr);

    buddy_starve_ctr #(.STARVE_LIM(STARVE_LIM)) u_starve (
        .clk     (clk),
        .rst_n   (rst_n),
        .deny    (buddy_mode && blocked[BUDDY]),
        .promote (prio_buddy)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_idle
        blocked_idle_ctr #(.CNT_W(CNT_W)) u_idle (
            .clk     (clk),
            .rst_n   (rst_n),
            .blocked (blocked[c]),
            .count   (idle_cnt[c])
        );
    end

    always_comb begin
        cmd_d.rd_cmd = gnt.rd;
        cmd_d.wr_cmd = gnt.wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign rd_gnt       = gnt.rd;
    assign wr_gnt       = gnt.wr;
    assign rd_cmd       = cmd_q.rd_cmd;
    assign wr_cmd       = cmd_q.wr_cmd;
    assign idle_striped = idle_cnt[STRIPED];
    assign idle_buddy   = idle_cnt[BUDDY];

    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_gnt & ~rd_req) == 2'b00) && ((wr_gnt & ~wr_req) == 2'b00));

    assert_one_cmd_per_chan_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt & wr_gnt) == 2'b00);

    assert_shared_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        buddy_mode |-> ($countones(rd_gnt) <= 1 && $countones(wr_gnt) <= 1));

    assert_cross_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (buddy_mode && rd_req[0] && wr_req[1]) |-> ($countones(rd_gnt | wr_gnt) == 2));

    assert_independent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !buddy_mode |-> ((rd_gnt | wr_gnt) == (rd_req | wr_req)));

    assert_cmd_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rd_cmd == $past(rd_gnt)) && (wr_cmd == $past(wr_gnt)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req[0] || wr_req[0]) |=> $stable(idle_striped));
endmodule

// File: tb/sim_shared_port_sched.sv
module sim_shared_port_sched;
    localparam int LIM = 4;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic buddy_mode = 1'b0;
    logic [1:0] rd_req = '0, wr_req = '0;
    logic [1:0] rd_gnt, wr_gnt, rd_cmd, wr_cmd;
    logic [CW-1:0] idle_striped, idle_buddy;

    int checks = 0;
    int errors = 0;
    int mstarve = 0;
    logic [CW-1:0] midle0 = '0, midle1 = '0;

    shared_port_sched #(.STARVE_LIM(LIM), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .buddy_mode(buddy_mode),
        .rd_req(rd_req), .wr_req(wr_req), .rd_gnt(rd_gnt), .wr_gnt(wr_gnt),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
        .idle_striped(idle_striped), .idle_buddy(idle_buddy)
    );

    always #5 clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // returns {wr, rd} per the requirements
    function automatic logic [3:0] model(logic [1:0] r, logic [1:0] w, logic m, logic p);
        logic [1:0] gr = 2'b00, gw = 2'b00;
        logic [1:0] pm = p ? 2'b10 : 2'b01;
        logic a = r[0] & w[1];
        logic b = r[1] & w[0];
        if (!m) begin
            for (int c = 0; c < 2; c++) begin
                if (r[c]) gr[c] = 1'b1;
                else if (w[c]) gw[c] = 1'b1;
            end
        end else if (a && b) begin
            gr = pm; gw = ~pm;
        end else if (a) begin
            gr = 2'b01; gw = 2'b10;
        end else if (b) begin
            gr = 2'b10; gw = 2'b01;
        end else if (r != 2'b00) begin
            gr = (r == 2'b11) ? pm : r;
        end else if (w != 2'b00) begin
            gw = (w == 2'b11) ? pm : w;
        end
        return {gw, gr};
    endfunction

    task automatic step(string tag, logic [1:0] r, logic [1:0] w, logic m);
        logic [3:0] e;
        logic [1:0] got;
        @(negedge clk);
        rd_req = r; wr_req = w; buddy_mode = m;
        #2;
        e = model(r, w, m, mstarve >= LIM);
        check(tag, {28'd0, wr_gnt, rd_gnt}, {28'd0, e});
        check("R2", {30'd0, (rd_gnt & ~r) | (wr_gnt & ~w) | (rd_gnt & wr_gnt)}, 32'd0);
        if (m) check("R3", ($countones(rd_gnt) > 1 || $countones(wr_gnt) > 1) ? 1 : 0, 0);
        got = e[1:0] | e[3:2];
        @(posedge clk);
        #1;
        check("R8", {28'd0, wr_cmd, rd_cmd}, {28'd0, e});
        if ((r[0] | w[0]) && !got[0]) midle0 = midle0 + 1'b1;
        if ((r[1] | w[1]) && !got[1]) midle1 = midle1 + 1'b1;
        if (m && (r[1] | w[1]) && !got[1]) mstarve = (mstarve >= LIM) ? LIM : mstarve + 1;
        else mstarve = 0;
        check("R9", {16'd0, idle_striped}, {16'd0, midle0});
        check("R9", {16'd0, idle_buddy}, {16'd0, midle1});
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rd_req = 2'b11; wr_req = 2'b11; buddy_mode = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {28'd0, wr_cmd, rd_cmd}, 32'd0);
        check("R1", {idle_buddy, idle_striped}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: striped holds priority right after reset
        step("R1", 2'b11, 2'b00, 1'b1);
        // R6: all reads contend, buddy promoted after LIM denials
        for (int i = 0; i < 12; i++) step("R6", 2'b11, 2'b00, 1'b1);
        for (int i = 0; i < 12; i++) step("R6", 2'b00, 2'b11, 1'b1);
        // R4: pairing, single and double
        step("R4", 2'b01, 2'b10, 1'b1);
        step("R4", 2'b10, 2'b01, 1'b1);
        step("R4", 2'b11, 2'b11, 1'b1);
        // R5: same channel read and write, read wins; other conflicts
        step("R5", 2'b01, 2'b01, 1'b1);
        step("R5", 2'b10, 2'b10, 1'b1);
        step("R5", 2'b11, 2'b00, 1'b1);
        // R7: independent channels
        step("R7", 2'b11, 2'b11, 1'b0);
        step("R7", 2'b11, 2'b00, 1'b0);
        step("R7", 2'b00, 2'b11, 1'b0);
        step("R7", 2'b01, 2'b10, 1'b0);
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] r = 2'($urandom);
            logic [1:0] w = 2'($urandom);
            logic m = ($urandom % 4) != 0;
            step(m ? "R4" : "R7", r, w, m);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule